// File: doc/BRIEF.md
# Partitioned 128-bit Lane Arithmetic Unit

This block performs one packed-integer operation per cycle on two 128-bit operands, `rs_i` and `rt_i`. A lane-size code divides both operands into sixteen byte lanes, eight halfword lanes or four word lanes. Every lane is computed on its own, and no carry, borrow or sign ever crosses a lane boundary. The operation set covers wrapping add and subtract, signed and unsigned saturating add and subtract, a signed greater-than compare, an equality compare, signed lane minimum and maximum, saturating absolute value, and a mixed halfword subtract/add. The four full-width bitwise operations ignore the lane size.

The unit has exactly one register stage, with a synchronous active-high reset. A request is presented with `valid_i`, and its result appears one cycle later together with `valid_o`. The unit also returns a destination write enable. That enable stays low when the destination index is 0. It also stays low when the opcode and lane size do not form a supported pair; in that case the unit raises `illegal_o` and returns a zero result.

Top module: `simd_lane_alu`

## Requirements
- R1: The lane-size code selects the lane width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits, and 3 gives no lane width. Opcode 0 adds rs+rt and opcode 1 subtracts rs-rt. Both wrap modulo 2^width in every lane, and a lane's carry or borrow never reaches its neighbour.
- R2: Opcode 2 (add) and opcode 3 (subtract, rs-rt) treat lanes as signed. A result above the largest signed lane value becomes that value, and a result below the smallest becomes the smallest.
- R3: Opcode 4 is an unsigned add that clamps to all ones on overflow. Opcode 5 is an unsigned subtract rs-rt that clamps to zero when rt>rs.
- R4: Opcode 6 writes all ones to a lane when signed rs > signed rt, and all zeros otherwise. Opcode 7 writes all ones when the two lanes are equal, and all zeros otherwise.
- R5: Opcodes 12, 13, 14 and 15 give rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt) over all 128 bits. They are legal with every lane-size code, including 3.
- R6: Opcode 8 gives the signed maximum and opcode 9 the signed minimum of rs and rt, lane by lane, for halfword and word lanes.
- R7: Opcode 10 gives the absolute value of each signed rt lane, for halfword and word lanes. The most negative value returns the most positive value.
- R8: Opcode 11 works on halfword lanes only. It computes rs-rt (wrapping) in even lanes (lane 0 = bits 15:0) and rs+rt (wrapping) in odd lanes.
- R9: A request with destination index 0 keeps `wen_o` low. Its result is still returned.
- R10: An unsupported pair raises `illegal_o`, holds `wen_o` low and returns zero. Unsupported pairs are: opcodes 0 to 11 with lane code 3; opcodes 8, 9 and 10 with byte lanes; opcode 11 with any lane code other than 1.
- R11: The outputs for a request appear exactly one cycle after `valid_i`. In a cycle that follows no request, `valid_o`, `wen_o` and `illegal_o` are low and the result is zero.
- R12: A synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request present |
| op_i | input | 4 | Operation code |
| lsz_i | input | 2 | Lane-size code |
| dst_i | input | 5 | Destination register index |
| rs_i | input | 128 | First operand |
| rt_i | input | 128 | Second operand |
| valid_o | output | 1 | Result present |
| wen_o | output | 1 | Destination write enable |
| illegal_o | output | 1 | Unsupported opcode/lane-size pair |
| result_o | output | 128 | Lane result |

## Verification
The only state the unit holds is its output register. A fault in lane wiring, clamp selection or legality decode therefore shows up on `result_o`, `wen_o` or `illegal_o` in the cycle straight after the offending request, and it cannot hide until later. The bench aims stimulus at lane boundaries: all-ones plus one, extreme signed values, and the most negative absolute value. A carry leaking between lanes, a clamp applied in the wrong direction, or an even/odd swap changes a specific lane of the very next result.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [1:0] {
    LSZ_B = 2'd0,
    LSZ_H = 2'd1,
    LSZ_W = 2'd2,
    LSZ_X = 2'd3
  } lsz_e;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDS = 4'd2,
    OP_SUBS = 4'd3,
    OP_ADDU = 4'd4,
    OP_SUBU = 4'd5,
    OP_CGT  = 4'd6,
    OP_CEQ  = 4'd7,
    OP_MAX  = 4'd8,
    OP_MIN  = 4'd9,
    OP_ABS  = 4'd10,
    OP_ADSB = 4'd11,
    OP_AND  = 4'd12,
    OP_OR   = 4'd13,
    OP_XOR  = 4'd14,
    OP_NOR  = 4'd15
  } op_e;
endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
  import simd_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic         odd,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   usum, udif, ssum, sdif;
  logic         gt, eq;
  logic [W-1:0] negb, absb;

  always_comb begin
    usum = {1'b0, a} + {1'b0, b};
    udif = {1'b0, a} - {1'b0, b};
    ssum = {a[W-1], a} + {b[W-1], b};
    sdif = {a[W-1], a} - {b[W-1], b};
    gt   = $signed(a) > $signed(b);
    eq   = (a == b);
    negb = '0 - b;
    absb = b[W-1] ? ((b == SMIN) ? SMAX : negb) : b;
  end

  always_comb begin
    case (op)
      OP_ADD:  y = usum[W-1:0];
      OP_SUB:  y = udif[W-1:0];
      OP_ADDS: y = (ssum[W] != ssum[W-1]) ? (ssum[W] ? SMIN : SMAX) : ssum[W-1:0];
      OP_SUBS: y = (sdif[W] != sdif[W-1]) ? (sdif[W] ? SMIN : SMAX) : sdif[W-1:0];
      OP_ADDU: y = usum[W] ? '1 : usum[W-1:0];
      OP_SUBU: y = udif[W] ? '0 : udif[W-1:0];
      OP_CGT:  y = gt ? '1 : '0;
      OP_CEQ:  y = eq ? '1 : '0;
      OP_MAX:  y = gt ? a : b;
      OP_MIN:  y = gt ? b : a;
      OP_ABS:  y = absb;
      OP_ADSB: y = odd ? usum[W-1:0] : udif[W-1:0];
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int W      = 16
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int LANES = DATA_W / W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic ODD = ((i % 2) == 1);
    simd_lane_op #(.W(W)) u_op (
      .op  (op),
      .odd (ODD),
      .a   (a[i*W +: W]),
      .b   (b[i*W +: W]),
      .y   (y[i*W +: W])
    );
  end
endmodule

// File: rtl/simd_op_decode.sv
module simd_op_decode
  import simd_alu_pkg::*;
(
  input  op_e  op,
  input  lsz_e lsz,
  output logic legal,
  output logic bitwise
);
  always_comb begin
    bitwise = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
    if (bitwise)
      legal = 1'b1;
    else if (lsz == LSZ_X)
      legal = 1'b0;
    else if (op == OP_MAX || op == OP_MIN || op == OP_ABS)
      legal = (lsz != LSZ_B);
    else if (op == OP_ADSB)
      legal = (lsz == LSZ_H);
    else
      legal = 1'b1;
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        lsz_i,
  input  logic [IDX_W-1:0]  dst_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  output logic              valid_o,
  output logic              wen_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] result_o
);
  op_e  op;
  lsz_e lsz;
  logic legal, bitwise;
  logic [DATA_W-1:0] r8, r16, r32, rbit, rsel;

  assign op  = op_e'(op_i);
  assign lsz = lsz_e'(lsz_i);

  simd_op_decode u_dec (
    .op      (op),
    .lsz     (lsz),
    .legal   (legal),
    .bitwise (bitwise)
  );

  simd_lane_bank #(.DATA_W(DATA_W), .W(8))  u_b8  (.op(op), .a(rs_i), .b(rt_i), .y(r8));
  simd_lane_bank #(.DATA_W(DATA_W), .W(16)) u_b16 (.op(op), .a(rs_i), .b(rt_i), .y(r16));
  simd_lane_bank #(.DATA_W(DATA_W), .W(32)) u_b32 (.op(op), .a(rs_i), .b(rt_i), .y(r32));

  always_comb begin
    case (op)
      OP_AND:  rbit = rs_i & rt_i;
      OP_OR:   rbit = rs_i | rt_i;
      OP_XOR:  rbit = rs_i ^ rt_i;
      default: rbit = ~(rs_i | rt_i);
    endcase
    if (bitwise)
      rsel = rbit;
    else begin
      case (lsz)
        LSZ_B:   rsel = r8;
        LSZ_H:   rsel = r16;
        LSZ_W:   rsel = r32;
        default: rsel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      wen_o     <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o   <= valid_i;
      wen_o     <= valid_i && legal && (dst_i != '0);
      illegal_o <= valid_i && !legal;
      result_o  <= (valid_i && legal) ? rsel : '0;
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [1:0]        lsz_i,
  input logic [IDX_W-1:0]  dst_i,
  input logic [DATA_W-1:0] rs_i,
  input logic [DATA_W-1:0] rt_i,
  input logic              valid_o,
  input logic              wen_o,
  input logic              illegal_o,
  input logic [DATA_W-1:0] result_o
);
  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (!valid_o && !wen_o && !illegal_o && result_o == '0));

  a_r9_dst_zero_no_write: assert property (@(posedge clk) disable iff (rst)
    (valid_i && dst_i == '0) |=> !wen_o);

  a_r10_no_lane_size: assert property (@(posedge clk) disable iff (rst)
    (valid_i && lsz_i == 2'd3 && op_i < 4'd12) |=> (illegal_o && !wen_o && result_o == '0));

  a_r5_full_and: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 4'd12) |=> (result_o == $past(rs_i & rt_i)));

  a_r4_eq_word_mask: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 4'd7 && lsz_i == 2'd2) |=>
      (result_o[31:0] == {32{$past(rs_i[31:0] == rt_i[31:0])}}));

  a_r7_abs_nonneg: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 4'd10 && lsz_i == 2'd1) |=> !result_o[15]);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!valid_o && !wen_o && !illegal_o));

  a_r10_flag_excludes_write: assert property (@(posedge clk) disable iff (rst)
    !(wen_o && illegal_o));
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/simd_lane_alu_tb.sv
`timescale 1ns/1ps
module simd_lane_alu_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid_i = 1'b0;
  logic [3:0]   op_i = '0;
  logic [1:0]   lsz_i = '0;
  logic [4:0]   dst_i = '0;
  logic [127:0] rs_i = '0, rt_i = '0;
  logic         valid_o, wen_o, illegal_o;
  logic [127:0] result_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [127:0] res;
    logic         wen;
    logic         ill;
    string        tag;
  } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  simd_lane_alu u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .lsz_i(lsz_i),
    .dst_i(dst_i), .rs_i(rs_i), .rt_i(rt_i), .valid_o(valid_o),
    .wen_o(wen_o), .illegal_o(illegal_o), .result_o(result_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_legal(input logic [3:0] op, input logic [1:0] lsz);
    if (op >= 4'd12) return 1'b1;
    if (lsz == 2'd3) return 1'b0;
    if (op == 4'd8 || op == 4'd9 || op == 4'd10) return lsz != 2'd0;
    if (op == 4'd11) return lsz == 2'd1;
    return 1'b1;
  endfunction

  function automatic logic [127:0] model(input logic [3:0] op, input logic [1:0] lsz,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] res = '0;
    int w, n;
    longint full, hmax, hmin;
    case (op)
      4'd12: return a & b;
      4'd13: return a | b;
      4'd14: return a ^ b;
      4'd15: return ~(a | b);
      default: ;
    endcase
    if (!is_legal(op, lsz)) return '0;
    w = 8 << lsz;
    n = 128 / w;
    full = longint'(1) << w;
    hmax = full / 2 - 1;
    hmin = -(full / 2);
    for (int i = 0; i < n; i++) begin
      longint ua, ub, sa, sb, r;
      ua = longint'(a >> (i * w)) & (full - 1);
      ub = longint'(b >> (i * w)) & (full - 1);
      sa = (ua > hmax) ? ua - full : ua;
      sb = (ub > hmax) ? ub - full : ub;
      case (op)
        4'd0: r = ua + ub;
        4'd1: r = ua - ub;
        4'd2: begin r = sa + sb; if (r > hmax) r = hmax; if (r < hmin) r = hmin; end
        4'd3: begin r = sa - sb; if (r > hmax) r = hmax; if (r < hmin) r = hmin; end
        4'd4: r = (ua + ub > full - 1) ? full - 1 : ua + ub;
        4'd5: r = (ua < ub) ? 0 : ua - ub;
        4'd6: r = (sa > sb) ? -1 : 0;
        4'd7: r = (ua == ub) ? -1 : 0;
        4'd8: r = (sa > sb) ? sa : sb;
        4'd9: r = (sa < sb) ? sa : sb;
        4'd10: r = (sb < 0) ? ((-sb > hmax) ? hmax : -sb) : sb;
        default: r = ((i % 2) == 0) ? ua - ub : ua + ub;
      endcase
      res = res | ((128'(r & (full - 1))) << (i * w));
    end
    return res;
  endfunction

  task automatic send(input logic [3:0] op, input logic [1:0] lsz, input logic [4:0] dst,
                      input logic [127:0] a, input logic [127:0] b, input string tag);
    item_t it;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; lsz_i = lsz; dst_i = dst; rs_i = a; rt_i = b;
    it.res = model(op, lsz, a, b);
    it.ill = !is_legal(op, lsz);
    it.wen = is_legal(op, lsz) && (dst != 0);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R11 unexpected result", result_o, '0);
      end else begin
        item_t e;
        e = sbq.pop_front();
        chk(result_o == e.res, {e.tag, " result"}, result_o, e.res);
        chk(wen_o == e.wen, {e.tag, " wen"}, 128'(wen_o), 128'(e.wen));
        chk(illegal_o == e.ill, {e.tag, " illegal"}, 128'(illegal_o), 128'(e.ill));
      end
    end
  end

  function automatic logic [127:0] rep8(input logic [7:0] v);   return {16{v}}; endfunction
  function automatic logic [127:0] rep16(input logic [15:0] v); return {8{v}};  endfunction
  function automatic logic [127:0] rep32(input logic [31:0] v); return {4{v}};  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!valid_o && !wen_o && !illegal_o && result_o == '0, "R12 reset state", result_o, '0);
    rst = 1'b0;

    send(4'd0, 2'd0, 5'd3, rep8(8'hFF), rep8(8'h01), "R1 byte add wrap");
    send(4'd1, 2'd1, 5'd3, rep16(16'h0000), rep16(16'h0001), "R1 half sub wrap");
    send(4'd0, 2'd2, 5'd3, rep32(32'hFFFF_FFFF), {96'd0, 32'd1}, "R1 word add lane carry");
    send(4'd2, 2'd0, 5'd4, rep8(8'h7F), rep8(8'h01), "R2 byte sat pos");
    send(4'd3, 2'd1, 5'd4, rep16(16'h8000), rep16(16'h0001), "R2 half sat neg");
    send(4'd2, 2'd2, 5'd4, rep32(32'h8000_0000), rep32(32'hFFFF_FFFF), "R2 word sat neg");
    send(4'd4, 2'd0, 5'd5, rep8(8'hF0), rep8(8'h20), "R3 byte unsigned add clamp");
    send(4'd5, 2'd2, 5'd5, rep32(32'd5), rep32(32'd9), "R3 word unsigned sub clamp");
    send(4'd6, 2'd0, 5'd6, rep8(8'h01), rep8(8'hFF), "R4 byte gt signed");
    send(4'd6, 2'd1, 5'd6, rep16(16'h0003), rep16(16'h0003), "R4 half gt equal");
    send(4'd7, 2'd2, 5'd6, {32'd1, 32'd2, 32'd3, 32'd4}, {32'd1, 32'd0, 32'd3, 32'd0}, "R4 word eq mask");
    send(4'd12, 2'd3, 5'd7, {4{32'hF0F0_1234}}, {4{32'h0FF0_FFFF}}, "R5 and size3");
    send(4'd13, 2'd0, 5'd7, {4{32'hF0F0_1234}}, {4{32'h0FF0_0000}}, "R5 or");
    send(4'd14, 2'd1, 5'd7, {4{32'hAAAA_5555}}, {4{32'hFFFF_0000}}, "R5 xor");
    send(4'd15, 2'd2, 5'd7, {4{32'hAAAA_0000}}, {4{32'h0000_5555}}, "R5 nor");
    send(4'd8, 2'd1, 5'd8, rep16(16'h8000), rep16(16'h0001), "R6 half max");
    send(4'd9, 2'd2, 5'd8, rep32(32'h7FFF_FFFF), rep32(32'hFFFF_FFFE), "R6 word min");
    send(4'd10, 2'd1, 5'd9, '0, {16'h8000, 16'hFFFF, 16'h0005, 16'h7FFF, 16'h8001, 16'd0, 16'hFFFE, 16'h8000}, "R7 half abs");
    send(4'd10, 2'd2, 5'd9, '0, {32'h8000_0000, 32'hFFFF_FFFF, 32'd7, 32'h8000_0001}, "R7 word abs");
    send(4'd11, 2'd1, 5'd10, rep16(16'd10), rep16(16'd3), "R8 sub even add odd");
    send(4'd0, 2'd0, 5'd0, rep8(8'h11), rep8(8'h22), "R9 dst zero");
    send(4'd10, 2'd0, 5'd11, '0, rep8(8'h80), "R10 abs byte");
    send(4'd11, 2'd2, 5'd11, rep32(32'd1), rep32(32'd2), "R10 addsub word");
    send(4'd0, 2'd3, 5'd11, rep32(32'd1), rep32(32'd2), "R10 add no size");
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!valid_o && !wen_o && !illegal_o && result_o == '0, "R11 idle outputs", result_o, '0);

    for (int k = 0; k < 400; k++) begin
      logic [127:0] a, b;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if (k % 4 == 1) a = rep8(8'h80) ^ (a & rep8(8'h01));
      if (k % 4 == 2) b = rep16(16'h7FFF) ^ (b & rep16(16'h0001));
      send(4'($urandom % 16), 2'($urandom % 4), 5'($urandom % 32), a, b, "R1 R2 R3 R4 R6 R8 R10 mixed");
    end
    @(negedge clk);
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R11 all results returned", 128'(sbq.size()), '0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      chk(1'b0, "R11 watchdog expired", '0, '1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule